// File: doc/BRIEF.md
# Receive Character Buffer with Hardware Flow Control

This block sits between a UART receiver and the register interface of a serial port. Each character the receiver assembles is pushed into a 16-entry first-in first-out buffer. The register interface pops characters with a read strobe and always sees the oldest stored character on the read data output. The block reports the buffer's fill level, an empty flag and a full flag. A character that arrives while the buffer is full is discarded, and the block flags the loss with a one-cycle pulse.

The block also drives an active-low request-to-send line toward the remote transmitter. Automatic pacing runs only when three control bits are all set: the manual request bit, the auto-flow enable and the buffer enable. In that mode the line goes inactive once the fill level reaches one of four selectable thresholds. It does not return active when the level falls below the threshold. It returns active only after the buffer has been read down to zero. This hysteresis keeps the remote side from sending again until all stored data has been drained. When any of the three bits is clear, the line is the plain inverse of the manual request bit.

Top module: `rx_fifo_autorts`

## Requirements
- R1: Characters leave in the order they were accepted, and `rd_data` always shows the oldest stored character while `empty` is low.
- R2: `level` counts the stored characters (0 to 16). `empty` is high exactly at level 0 and `full` exactly at level 16. A read and a write in the same cycle leave the level unchanged. A read strobe on an empty buffer has no effect.
- R3: A write strobe while the buffer is full, with no read in the same cycle, stores nothing. In the following cycle `overrun` is high for exactly one cycle. A write together with a read on a full buffer is accepted and gives no overrun.
- R4: Automatic pacing is active only while `rts_bit`, `afe_bit` and `fifo_en` are all 1. `trig_sel` chooses the threshold as follows: 0 gives 1 character, 1 gives 4, 2 gives 8 and 3 gives 14.
- R5: With automatic pacing active, `rts_n` is 1 from the clock edge at which the updated level becomes equal to or greater than the threshold.
- R6: With automatic pacing active, once `rts_n` is 1 it stays 1 while the level is above zero, whatever the threshold. It returns to 0 at the edge at which the updated level becomes 0.
- R7: With automatic pacing inactive, `rts_n` equals the inverse of `rts_bit`, registered at each clock edge.
- R8: After asynchronous reset the buffer is empty (`level` 0, `empty` 1, `full` 0), `overrun` is 0 and `rts_n` is 1.
- R9: The buffer keeps accepting characters while `rts_n` is inactive, up to 16 characters. With the 14-character threshold this leaves room for two more characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver has a character to store |
| wr_data | input | 8 | Received character |
| rd_en | input | 1 | Pop the oldest character |
| rts_bit | input | 1 | Manual request-to-send control bit |
| afe_bit | input | 1 | Auto-flow enable bit |
| fifo_en | input | 1 | Buffer enable bit |
| trig_sel | input | 2 | Threshold select |
| rd_data | output | 8 | Oldest stored character |
| level | output | 5 | Number of stored characters |
| empty | output | 1 | Buffer holds nothing |
| full | output | 1 | Buffer holds 16 characters |
| overrun | output | 1 | One-cycle pulse after a dropped character |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The assertions assume that control inputs change only between clock edges and that the reset is applied before the first read or write strobe. They compare `rts_n` against the level that was registered at the same edge. For this reason they depend on the threshold select being held when the edge samples it. The stimulus changes the control bits and the threshold only half a cycle away from the sampling edge. Between scenarios it drains the buffer, so that each threshold is approached from a known level. The directed phases are followed by a pseudo-random phase that mixes reads, writes, overflow attempts and mode changes.

// File: rtl/rx_fifo_autorts.sv
module rx_fifo_autorts #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rts_bit,
  input  logic          afe_bit,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          rts_n
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt, cnt_n, thr;
  logic          push, pop, auto_on, hold, hold_n;

  assign pop     = rd_en && (cnt != '0);
  assign push    = wr_en && ((cnt != LW'(DEPTH)) || pop);
  assign auto_on = rts_bit && afe_bit && fifo_en;

  always_comb begin
    cnt_n = cnt;
    if (push && !pop) cnt_n = cnt + 1'b1;
    else if (pop && !push) cnt_n = cnt - 1'b1;
  end

  always_comb begin
    case (trig_sel)
      2'd0:    thr = LW'(1);
      2'd1:    thr = LW'(DEPTH / 4);
      2'd2:    thr = LW'(DEPTH / 2);
      default: thr = LW'(DEPTH - 2);
    endcase
  end

  assign hold_n = auto_on && ((cnt_n >= thr) || (hold && (cnt_n != '0)));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      hold    <= 1'b0;
      overrun <= 1'b0;
      rts_n   <= 1'b1;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt     <= cnt_n;
      hold    <= hold_n;
      overrun <= wr_en && !push;
      rts_n   <= auto_on ? hold_n : !rts_bit;
    end
  end

  assign rd_data = mem[rp];
  assign level   = cnt;
  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));

endmodule

// File: rtl/rx_fifo_autorts_chk.sv
module rx_fifo_autorts_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rts_bit,
  input logic          afe_bit,
  input logic          fifo_en,
  input logic [1:0]    trig_sel,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          overrun,
  input logic          rts_n
);

  logic          auto_c;
  logic [LW-1:0] lim;

  assign auto_c = rts_bit && afe_bit && fifo_en;
  assign lim = (trig_sel == 2'd0) ? LW'(1) :
               (trig_sel == 2'd1) ? LW'(DEPTH / 4) :
               (trig_sel == 2'd2) ? LW'(DEPTH / 2) : LW'(DEPTH - 2);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LW'(DEPTH)) && (empty == (level == '0)) && (full == (level == LW'(DEPTH))));

  assert_level_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && !empty) |=> $stable(level));

  assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(full) && $past(wr_en) && !$past(rd_en)));

  assert_thresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c |=> ((level < $past(lim)) || rts_n));

  assert_drain_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_c |=> ((level != '0) || !rts_n));

  assert_hyst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts_n) && $past(auto_c)) |-> (level == '0));

  assert_manual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_c |=> (rts_n == !$past(rts_bit)));

endmodule

bind rx_fifo_autorts rx_fifo_autorts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rts_bit(rts_bit), .afe_bit(afe_bit), .fifo_en(fifo_en), .trig_sel(trig_sel),
  .level(level), .empty(empty), .full(full), .overrun(overrun), .rts_n(rts_n)
);

// File: tb/rx_fifo_autorts_bench.sv
`timescale 1ns/1ps
module rx_fifo_autorts_bench;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, rts_bit = 0, afe_bit = 0, fifo_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       empty, full, overrun, rts_n;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  bit m_hold = 0, m_rts = 1, m_ovr = 0;
  logic [7:0] seq_v = 8'h10;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rx_fifo_autorts u_rx_fifo_autorts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rts_bit(rts_bit), .afe_bit(afe_bit), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .rd_data(rd_data), .level(level), .empty(empty), .full(full),
    .overrun(overrun), .rts_n(rts_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int thr_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic compare_all();
    bit au;
    au = rts_bit && afe_bit && fifo_en;
    chk("R2", "level", level, q.size());
    chk("R2", "empty", empty, q.size() == 0);
    chk("R2", "full", full, q.size() == 16);
    chk("R3", "overrun", overrun, m_ovr);
    if (q.size() > 0) chk("R1", "rd_data", rd_data, q[0]);
    if (!au) chk("R7", "rts_n manual", rts_n, m_rts);
    else if (m_hold) chk("R6", "rts_n held", rts_n, m_rts);
    else chk("R5", "rts_n auto", rts_n, m_rts);
  endtask

  task automatic step(bit w, bit r);
    bit pop, push, au;
    int t;
    @(negedge clk);
    wr_en = w; rd_en = r;
    if (w) begin wr_data = seq_v; seq_v = seq_v + 8'd7; end
    @(posedge clk);
    pop  = r && q.size() > 0;
    push = w && (q.size() < 16 || pop);
    m_ovr = w && !push;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(wr_data);
    au = rts_bit && afe_bit && fifo_en;
    t = thr_of(trig_sel);
    if (au) m_hold = (q.size() >= t) || (m_hold && q.size() != 0);
    else m_hold = 0;
    m_rts = au ? m_hold : !rts_bit;
    #1 compare_all();
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 1);
    step(0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23;
    chk("R8", "level after reset", level, 0);
    chk("R8", "empty after reset", empty, 1);
    chk("R8", "full after reset", full, 0);
    chk("R8", "overrun after reset", overrun, 0);
    chk("R8", "rts_n after reset", rts_n, 1);
    @(negedge clk); rst_n = 1;

    // R7 manual mode
    rts_bit = 1; step(0, 0);
    chk("R7", "rts_n follows bit=1", rts_n, 0);
    rts_bit = 0; step(1, 0);
    chk("R7", "rts_n follows bit=0", rts_n, 1);
    drain();

    // R4 R5 R6 each threshold
    rts_bit = 1; afe_bit = 1; fifo_en = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      step(0, 0);
      for (int k = 0; k < thr_of(2'(s)) - 1; k++) step(1, 0);
      chk("R5", "below threshold active", rts_n, 0);
      step(1, 0);
      chk("R5", "threshold reached", rts_n, 1);
      step(1, 0);
      chk("R9", "accepted after rts high", level, thr_of(2'(s)) + 1);
      while (q.size() > 1) step(0, 1);
      chk("R6", "held with one left", rts_n, 1);
      step(0, 1);
      chk("R6", "released on empty", rts_n, 0);
    end

    // R9 R3 fill past threshold 14 to full and overrun
    trig_sel = 2'd3;
    for (int k = 0; k < 16; k++) step(1, 0);
    chk("R9", "full with rts high", level, 16);
    step(1, 0);
    step(0, 0);
    chk("R3", "overrun single pulse", overrun, 0);
    step(1, 1);
    chk("R3", "rw on full no overrun", overrun, 0);
    chk("R2", "rw keeps level", level, 16);

    // R4 buffer disable reverts to manual
    fifo_en = 0; step(0, 0);
    chk("R4", "fifo_en off manual", rts_n, 0);
    fifo_en = 1; afe_bit = 0; step(0, 0);
    chk("R4", "afe off manual", rts_n, 0);
    afe_bit = 1;
    drain();
    step(0, 1);
    chk("R2", "read on empty ignored", level, 0);
    step(1, 1);
    chk("R2", "rw on empty stores", level, 1);
    drain();

    // mixed pseudo-random phase
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 200 == 0) begin
        trig_sel = lfsr[1:0];
        rts_bit = lfsr[2] | lfsr[5];
        afe_bit = lfsr[3] | lfsr[6];
        fifo_en = lfsr[4] | lfsr[7];
      end
      step(lfsr[8] | lfsr[9], lfsr[10] & lfsr[11]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule